// File: doc/BRIEF.md
# Majority-Vote Bit Sampler

The block recovers one data bit from a serial line that has been oversampled by the local clock. While its enable is high it takes one sample of the line per clock edge and counts how many samples in a window of fixed length saw the line high. When the window closes it drives the recovered bit by comparing that count with a threshold. It raises an error flag when the samples disagreed, and it pulses a ready strobe for a single cycle so that a downstream stage can capture the bit.

The last sample of a window counts toward that window's decision. The running count plus the present input is formed combinationally, and the decision registers load the comparison of that sum at the same edge that takes the final sample. Window length and threshold are parameters. The window length must be at least 2, and the threshold must lie between 1 and the window length. Clock recovery and the alignment of windows to bit edges are left to the surrounding logic.

Top module: `maj_bit_sampler`

## Requirements
- R1: A window is WIN_LEN (default 6) clock edges with `en` high. One sample of `din` is taken at each such edge. `rdy_o` goes high after the edge that takes the WIN_LEN-th sample, and at no other time.
- R2: At the end of a window `bit_o` is 1 when the count of high samples in that window is at least THRESH (default 4), and 0 otherwise.
- R3: At the end of a window `err_o` is 0 when every sample of the window was high or every sample was low, and 1 for any mixed window.
- R4: `rdy_o` is high for exactly one clock cycle per completed window and is low in the following cycle.
- R5: The final sample of a window is included in that window's decision. `bit_o`, `err_o` and `rdy_o` reflect the window in the cycle right after the edge that takes that sample.
- R6: The sample count and the high-sample count return to zero when a window completes. The next window starts with the next enabled edge and is not influenced by earlier windows.
- R7: An edge with `en` low takes no sample, does not advance the window, and ignores `din`.
- R8: `bit_o` and `err_o` keep their values between window completions.
- R9: An asynchronous active-low reset `rst_n` clears the window state and drives `bit_o`, `err_o` and `rdy_o` to 0. A window that was in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Sample enable; a sample is taken on each rising edge where it is high |
| din | input | 1 | Oversampled serial line |
| bit_o | output | 1 | Recovered bit of the last completed window |
| err_o | output | 1 | Set when the last completed window was not unanimous |
| rdy_o | output | 1 | One-cycle strobe marking a completed window |

## Verification
The checker assumes that `en` and `din` are stable around the rising edge and that reset release is aligned to the clock. It also assumes the window count starts at the first enabled edge after reset, because it tracks windows by counting enabled edges on its own. The stimulus changes inputs only on the falling edge and releases reset on a falling edge. Between enabled samples it inserts idle stretches in which `din` toggles against the intended value, so the ignore rule is exercised without breaking those assumptions.

// File: rtl/maj_pkg.sv
package maj_pkg;

  // Registered result of one completed window
  typedef struct packed {
    logic vote;
    logic mixed;
  } verdict_t;

  // True when a count of high samples means every sample agreed
  function automatic logic all_agree(input int unsigned ones, input int unsigned len);
    return (ones == 0) || (ones == len);
  endfunction

endpackage

// File: rtl/maj_win_cnt.sv
// Counts enabled edges inside a window and flags the closing sample.
module maj_win_cnt #(
  parameter int WIN_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic last_o
);
  localparam int CNT_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign last_o = (cnt_q == LAST_IDX);

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (last_o) cnt_d = '0;
      else        cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/maj_ones_acc.sv
// Accumulates high samples; exposes the running count plus the current sample.
module maj_ones_acc #(
  parameter int WIN_LEN = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               en,
  input  logic                               din,
  input  logic                               last,
  output logic [$clog2(WIN_LEN+1)-1:0]       nsum_o
);
  localparam int SUM_W = $clog2(WIN_LEN + 1);

  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] acc_d;

  // Combinational next sum: the closing sample is included here
  assign nsum_o = acc_q + SUM_W'(din);

  always_comb begin
    acc_d = acc_q;
    if (en) acc_d = last ? '0 : nsum_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end
endmodule

// File: rtl/maj_decide.sv
// Turns the closing sum into the registered bit, error flag and strobe.
module maj_decide #(
  parameter int WIN_LEN = 6,
  parameter int THRESH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         last,
  input  logic [$clog2(WIN_LEN+1)-1:0] nsum,
  output logic                         bit_o,
  output logic                         err_o,
  output logic                         rdy_o
);
  import maj_pkg::*;

  localparam int SUM_W = $clog2(WIN_LEN + 1);
  localparam logic [SUM_W-1:0] THR_V = SUM_W'(THRESH);

  verdict_t vd_q;
  verdict_t vd_d;
  logic     rdy_q;
  logic     rdy_d;
  logic     close_w;

  assign close_w = en && last;

  always_comb begin
    vd_d  = vd_q;
    rdy_d = 1'b0;
    if (close_w) begin
      vd_d.vote  = (nsum >= THR_V);
      vd_d.mixed = !all_agree(int'(nsum), WIN_LEN);
      rdy_d      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_q  <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      if (close_w) vd_q <= vd_d;
    end
  end

  assign bit_o = vd_q.vote;
  assign err_o = vd_q.mixed;
  assign rdy_o = rdy_q;
endmodule

// File: rtl/maj_bit_sampler.sv
module maj_bit_sampler #(
  parameter int WIN_LEN = 6,
  parameter int THRESH  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic bit_o,
  output logic err_o,
  output logic rdy_o
);
  localparam int SUM_W = $clog2(WIN_LEN + 1);

  logic             last_w;
  logic [SUM_W-1:0] nsum_w;

  maj_win_cnt #(.WIN_LEN(WIN_LEN)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .last_o(last_w)
  );

  maj_ones_acc #(.WIN_LEN(WIN_LEN)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .din   (din),
    .last  (last_w),
    .nsum_o(nsum_w)
  );

  maj_decide #(.WIN_LEN(WIN_LEN), .THRESH(THRESH)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .last  (last_w),
    .nsum  (nsum_w),
    .bit_o (bit_o),
    .err_o (err_o),
    .rdy_o (rdy_o)
  );
endmodule

// File: rtl/maj_bit_sampler_chk.sv
module maj_bit_sampler_chk #(
  parameter int WIN_LEN = 6,
  parameter int THRESH  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic din,
  input logic bit_o,
  input logic err_o,
  input logic rdy_o
);
  // Port-level shadow of the window: counts enabled edges and high samples
  int unsigned seen_q;
  int unsigned high_q;
  logic        exp_rdy, exp_bit, exp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 0;
      high_q  <= 0;
      exp_rdy <= 1'b0;
      exp_bit <= 1'b0;
      exp_err <= 1'b0;
    end else begin
      exp_rdy <= 1'b0;
      if (en) begin
        if (seen_q + 1 == WIN_LEN) begin
          exp_rdy <= 1'b1;
          exp_bit <= (high_q + din) >= THRESH;
          exp_err <= !((high_q + din == 0) || (high_q + din == WIN_LEN));
          seen_q  <= 0; // R6: fresh window
          high_q  <= 0;
        end else begin
          seen_q <= seen_q + 1;
          high_q <= high_q + din;
        end
      end
    end
  end

  AST_RDY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) rdy_o == exp_rdy); // R1
  AST_VOTE_VALUE: assert property (@(posedge clk) disable iff (!rst_n) rdy_o |-> bit_o == exp_bit); // R2
  AST_MIXED_FLAG: assert property (@(posedge clk) disable iff (!rst_n) rdy_o |-> err_o == exp_err); // R3
  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rdy_o |=> !rdy_o); // R4
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !rdy_o |-> ($stable(bit_o) && $stable(err_o))); // R8
  AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) rdy_o |-> $past(en)); // R7

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!bit_o && !err_o && !rdy_o); // R9
    end
  end
endmodule

bind maj_bit_sampler maj_bit_sampler_chk #(.WIN_LEN(WIN_LEN), .THRESH(THRESH)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .en   (en),
  .din  (din),
  .bit_o(bit_o),
  .err_o(err_o),
  .rdy_o(rdy_o)
);

// File: tb/sim_maj_bit_sampler.sv
`timescale 1ns/1ps
module sim_maj_bit_sampler;
  localparam int W = 6;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic din = 1'b0;
  logic bit_o, err_o, rdy_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  logic [1:0] exp_q[$];
  logic prev_rdy = 1'b0;

  always #2.5 clk = ~clk;

  maj_bit_sampler #(.WIN_LEN(W), .THRESH(T)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din),
    .bit_o(bit_o), .err_o(err_o), .rdy_o(rdy_o)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // Driver: one window, pat[0] first, with gap idle edges before each sample
  task automatic send_window(input logic [W-1:0] pat, input int gap);
    int ones;
    ones = $countones(pat);
    exp_q.push_back({(ones >= T) ? 1'b1 : 1'b0,
                     (ones == 0 || ones == W) ? 1'b0 : 1'b1});
    for (int i = 0; i < W; i++) begin
      for (int g = 0; g < gap; g++) begin
        en  = 1'b0;
        din = ~pat[i]; // R7: junk while disabled
        @(negedge clk);
        if (i > 0) check("R7 no strobe when idle", {1'b0, rdy_o}, 2'b00);
      end
      en  = 1'b1;
      din = pat[i];
      @(negedge clk);
      if (i == W - 1) check("R5 decision at last sample edge", {1'b0, rdy_o}, 2'b01);
      else            check("R1 no strobe mid-window", {1'b0, rdy_o}, 2'b00);
    end
    en = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy_o) begin
        if (exp_q.size() == 0) begin
          check("R1 unexpected strobe", 2'b01, 2'b00);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          check("R2 recovered bit", {1'b0, bit_o}, {1'b0, e[1]});
          check("R3 error flag", {1'b0, err_o}, {1'b0, e[0]});
        end
        if (prev_rdy) check("R4 strobe longer than one cycle", 2'b01, 2'b00);
      end
      prev_rdy <= rdy_o;
    end else begin
      prev_rdy <= 1'b0;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic b_hold, e_hold;
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {bit_o, err_o}, 2'b00);
    check("R9 reset strobe", {1'b0, rdy_o}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    send_window(6'b111111, 0);   // all high: 1, no error
    send_window(6'b000000, 0);   // all low: 0, no error
    send_window(6'b001111, 0);   // exactly threshold: 1, mixed
    send_window(6'b000111, 0);   // one below: 0, mixed
    send_window(6'b100111, 0);   // R5: final sample lifts count to threshold
    send_window(6'b011111, 0);   // final low, five high
    send_window(6'b100000, 2);   // R7: gaps with junk, only last high
    send_window(6'b111111, 1);   // R6: back to unanimous after mixed

    // R8: results hold during a long idle stretch with a toggling line
    b_hold = bit_o;
    e_hold = err_o;
    for (int k = 0; k < 20; k++) begin
      en = 1'b0;
      din = k[0];
      @(negedge clk);
    end
    check("R8 bit/err hold between windows", {bit_o, err_o}, {b_hold, e_hold});
    check("R7 no strobe while disabled", {1'b0, rdy_o}, 2'b00);

    // R9: reset in the middle of a window discards the partial window
    for (int k = 0; k < 3; k++) begin
      en = 1'b1;
      din = 1'b1;
      @(negedge clk);
    end
    en = 1'b0;
    #1 rst_n = 1'b0;
    #1 check("R9 asynchronous clear", {bit_o, err_o}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    send_window(6'b000000, 0);   // R6/R9: fresh window, partial ones gone
    send_window(6'b110110, 0);   // four high: 1, mixed

    repeat (4) @(negedge clk);
    check("R1 every window produced a result", {1'b0, exp_q.size() == 0}, 2'b01);
    finish_run();
  end
endmodule